// File: doc/BRIEF.md
# Fair-share channel interrupt arbiter

This block decides which of several serial channels is handed to a shared service processor next. Each channel raises a level request line. The arbiter watches all lines on every clock and presents one winner as a grant index with a valid flag. The processor serves that channel and then pulses a one-cycle done signal, which frees the arbiter to choose again.

Selection is fair-share, not round-robin and not fixed priority. When a channel is granted, a bit is set for it in a served mask, and that channel cannot win again while any other requester is still unserved. Once no pending request is left outside the mask, the mask is cleared. A channel that is the only requester can therefore win again at once, so a busy line gets more turns than a quiet one without starving it. When more than one eligible channel is pending, the lowest index wins so that the result is repeatable.

Top module: `fair_irq_arb`

## Requirements
- R1: Out of reset, `gnt_valid_o` is low and the served mask is empty.
- R2: While no grant is held, a pending eligible request gives `gnt_valid_o` high after the next rising clock edge. `gnt_idx_o` names a channel whose request was high on that edge.
- R3: When several eligible channels request together, the one with the lowest index is granted.
- R4: A grant keeps `gnt_valid_o` high and `gnt_idx_o` unchanged until `done_i` is sampled high.
- R5: `done_i` sampled high at edge k drops `gnt_valid_o` after edge k. The next grant can appear no earlier than after edge k+1, and appears exactly then if an eligible request is pending.
- R6: A granted channel is not granted again while another channel that is pending and not yet served in the current round is waiting.
- R7: When no pending request lies outside the served mask, the mask is cleared, so a channel requesting alone is granted on every turn.
- R8: A request that is withdrawn before it is granted leaves no mark in the served mask. That channel is still eligible when it asks again in the same round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CH | Per-channel service request levels |
| done_i | input | 1 | One-cycle pulse: the processor has finished the granted channel |
| gnt_valid_o | output | 1 | A grant is held |
| gnt_idx_o | output | IDX_W | Index of the granted channel |

## Verification
The bench builds the arbiter with its default of eight channels, so the three-bit index and the full-width served mask are exercised. Request patterns on channels 0 to 6 cover a three-way contention round that wraps back to channel 0 and a lone channel winning again and again. They also cover two channels taking alternate turns, and a mid-round withdrawal followed by a new request.

// File: rtl/fair_arb_pkg.sv
package fair_arb_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_GRANT = 1'b1} arb_state_e;
endpackage

// File: rtl/fa_pick.sv
module fa_pick #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  vec_i,
  output logic [N_CH-1:0]  onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N_CH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_CH; i++) begin : g_chain
    assign onehot_o[i] = vec_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | vec_i[i];
  end

  assign any_o = seen[N_CH];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (onehot_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_mask.sv
module fa_mask #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic            upd_i,
  input  logic [N_CH-1:0] win_i,
  output logic [N_CH-1:0] elig_o
);
  logic [N_CH-1:0] served_q;
  logic [N_CH-1:0] fresh;
  logic            wrap;

  assign fresh  = req_i & ~served_q;
  assign wrap   = ~|fresh;
  // new round starts in the same cycle the old one runs dry
  assign elig_o = wrap ? req_i : fresh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      served_q <= '0;
    end else if (upd_i) begin
      served_q <= (wrap ? '0 : served_q) | win_i;
    end
  end
endmodule

// File: rtl/fair_irq_arb.sv
module fair_irq_arb
  import fair_arb_pkg::*;
#(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  req_i,
  input  logic             done_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  arb_state_e      state_q;
  logic [N_CH-1:0] elig;
  logic [N_CH-1:0] win;
  logic [IDX_W-1:0] win_idx;
  logic            win_any;
  logic            arb_en;
  logic [IDX_W-1:0] idx_q;

  assign arb_en = (state_q == ST_IDLE);

  fa_mask #(.N_CH(N_CH)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .upd_i  (arb_en),
    .win_i  (win),
    .elig_o (elig)
  );

  fa_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick (
    .vec_i    (elig),
    .onehot_o (win),
    .idx_o    (win_idx),
    .any_o    (win_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (win_any) begin
          state_q <= ST_GRANT;
          idx_q   <= win_idx;
        end
        ST_GRANT: if (done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt_valid_o = (state_q == ST_GRANT);
  assign gnt_idx_o   = idx_q;
endmodule

// File: rtl/fair_irq_arb_chk.sv
module fair_irq_arb_chk #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned IDX_W = $clog2(N_CH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  req_i,
  input logic             done_i,
  input logic             gnt_valid_o,
  input logic [IDX_W-1:0] gnt_idx_o
);
  logic [N_CH-1:0] req_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_d <= '0;
    else         req_d <= req_i;
  end

  // R2
  grant_to_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_valid_o) |-> req_d[gnt_idx_o]);

  // R4
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !done_i) |=> (gnt_valid_o && $stable(gnt_idx_o)));

  // R5
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && done_i) |=> !gnt_valid_o);

  // R5
  drop_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gnt_valid_o) |-> $past(done_i));

  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (int'(gnt_idx_o) < N_CH));
endmodule

bind fair_irq_arb fair_irq_arb_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .done_i      (done_i),
  .gnt_valid_o (gnt_valid_o),
  .gnt_idx_o   (gnt_idx_o)
);

// File: tb/fair_irq_arb_bench.sv
`timescale 1ns/1ps
module fair_irq_arb_bench;
  localparam int N_CH  = 8;
  localparam int IDX_W = $clog2(N_CH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_CH-1:0]  req = '0;
  logic             done = 1'b0;
  logic             gnt_valid;
  logic [IDX_W-1:0] gnt_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_q[$];
  logic prev_valid = 1'b0;

  always #2 clk = ~clk;

  fair_irq_arb #(.N_CH(N_CH)) u_fair_irq_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: every new grant is compared against the scoreboard (R3 R6 R7 R8)
  always @(negedge clk) begin
    if (rst_n && gnt_valid && !prev_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected grant", int'(gnt_idx), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(gnt_idx) == e, "R3/R6/R7/R8 grant order", int'(gnt_idx), e);
      end
    end
    prev_valid <= gnt_valid;
  end

  // serve the held grant, then apply next_req together with done
  task automatic serve(input logic [N_CH-1:0] next_req);
    int idx0;
    int w = 0;
    while (!gnt_valid && w < 20) begin @(negedge clk); w++; end
    chk(gnt_valid, "R2 grant appears", int'(gnt_valid), 1);
    idx0 = int'(gnt_idx);
    repeat (2) begin
      @(negedge clk);
      chk(gnt_valid && int'(gnt_idx) == idx0, "R4 grant held", int'(gnt_idx), idx0);
    end
    req  = next_req;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(!gnt_valid, "R5 release after done", int'(gnt_valid), 0);
    @(negedge clk);
    chk(gnt_valid == (next_req != '0), "R5 next grant one edge later",
        int'(gnt_valid), int'(next_req != '0));
  endtask

  task automatic start(input logic [N_CH-1:0] r);
    req = r;
    @(negedge clk);
    chk(gnt_valid, "R2 grant one edge after request", int'(gnt_valid), 1);
  endtask

  task automatic idle_gap();
    req = '0;
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R7 idle with no request", int'(gnt_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R1 reset state", int'(gnt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!gnt_valid, "R1 idle after reset", int'(gnt_valid), 0);

    // R3 R6: three contenders, round wraps to channel 0
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(0);
    start(8'h07);
    serve(8'h07); serve(8'h07); serve(8'h07); serve(8'h00);
    idle_gap();

    // R7: lone requester wins every turn
    exp_q.push_back(4); exp_q.push_back(4); exp_q.push_back(4);
    start(8'h10);
    serve(8'h10); serve(8'h10); serve(8'h00);
    idle_gap();

    // R6: two channels alternate
    exp_q.push_back(1); exp_q.push_back(6); exp_q.push_back(1); exp_q.push_back(6);
    start(8'h42);
    serve(8'h42); serve(8'h42); serve(8'h42); serve(8'h00);
    idle_gap();

    // R8: channel 3 withdrawn unserved stays eligible in the same round
    exp_q.push_back(0); exp_q.push_back(5); exp_q.push_back(3); exp_q.push_back(0);
    start(8'h09);
    serve(8'h21); serve(8'h09); serve(8'h09); serve(8'h00);
    idle_gap();

    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "R2 watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule